// File: doc/BRIEF.md
# Exact Leading-Zero Anticipator with Concurrent Error Detection

This block finds the normalization shift for an effective subtraction of two unsigned significands. It does not wait for the subtraction result. It forms an indicator string straight from the two operands. The first set bit of that string marks the leading one of the result, or the position one above it. Two trees work on this string side by side. A priority tree counts the zeros ahead of the first indicator bit. A pattern tree checks the digits below that bit, pairing positions two at a time at its first level. It raises a single correction flag when the leading one really sits one place lower. The counter output plus the flag gives the exact leading-zero count. The borrow chain of the subtractor is never on the correction path.

The operands are ordered internally by magnitude, so callers may present them either way round. The registered outputs are the absolute difference, the exact leading-zero count of that difference and a zero flag. They appear one clock after a valid input. When no valid input is presented the outputs keep their last values, and the valid strobe drops.

Top module: `lza_parallel_top`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `diff` equals the absolute value of `a_sig - b_sig` taken in that earlier cycle.
- R2: When the difference is nonzero, `lz_count` equals the number of zero bits above its most significant one, for every operand pair.
- R3: When `a_sig` equals `b_sig`, `diff` is 0, `zero` is 1 and `lz_count` equals the width W (32). Otherwise `zero` is 0.
- R4: `out_valid` is `in_valid` delayed by exactly one clock.
- R5: A cycle with `in_valid` low leaves `diff`, `lz_count` and `zero` unchanged, whatever the operands carry.
- R6: While `rst_n` is low on a rising clock edge, all outputs are cleared to 0.
- R7: When the first indicator bit lands one position above the true leading one, the count is corrected by one. Two examples: the pair (8, 3) gives 29, and the pair (8, 1) gives 29.
- R8: A long borrow run is counted exactly. The pair (0x80000000, 0x7FFFFFFF) gives count 31, and the pair (0x80000000, 0x7FFFFFFE) gives count 30.
- R9: Swapping the two operands yields the same `diff` and `lz_count`.
- R10: Extreme operands are handled. The pair (0xFFFFFFFF, 0) gives count 0, and the pair (0, 0) gives count 32 with `zero` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands valid this cycle |
| a_sig | input | W (32) | First significand |
| b_sig | input | W (32) | Second significand |
| out_valid | output | 1 | Registered results valid |
| diff | output | W (32) | Absolute difference of the operands |
| lz_count | output | clog2(W)+1 (6) | Exact leading-zero count of `diff` |
| zero | output | 1 | Difference is zero |

## Verification
The leading-zero counter and the pattern tree both settle in the same cycle. The final count is correct only when the tree's flag belongs to the same first indicator bit that the counter chose. The bench provokes this in two ways. It uses pairs whose digit string places a negative digit below the predicted position, such as (8, 3) and (8, 1). It also uses pairs that cut a long borrow run short, and pseudo-random near-equal pairs. Every result is judged against a bit-by-bit leading-zero count of the true difference, computed in the bench.

// File: rtl/lza_pkg.sv
package lza_pkg;

  // Summary of one segment of the signed-digit string d = x - y (digits -1/0/+1)
  typedef struct packed {
    logic v;    // segment holds an indicator bit
    logic nz;   // segment holds a nonzero digit
    logic neg;  // topmost nonzero digit of the segment is -1
    logic res;  // a nonzero digit lies below the segment's first indicator bit
    logic e;    // that digit is -1: prediction one place too high
  } enode_t;

  function automatic enode_t err_leaf(logic f, logic t, logic n);
    enode_t r;
    r.v   = f;
    r.nz  = t;
    r.neg = n;
    r.res = 1'b0;
    r.e   = 1'b0;
    return r;
  endfunction

  // hi covers the more significant half
  function automatic enode_t err_merge(enode_t hi, enode_t lo);
    enode_t r;
    r.v   = hi.v | lo.v;
    r.nz  = hi.nz | lo.nz;
    r.neg = hi.nz ? hi.neg : lo.neg;
    if (hi.v) begin
      r.res = hi.res | lo.nz;
      r.e   = hi.res ? hi.e : lo.neg;
    end else begin
      r.res = lo.res;
      r.e   = lo.e;
    end
    return r;
  endfunction

endpackage

// File: rtl/lza_prep.sv
module lza_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_sig,
  input  logic [W-1:0] b_sig,
  output logic [W-1:0] diff_c,
  output logic [W-1:0] t_vec,
  output logic [W-1:0] n_vec,
  output logic [W-1:0] f_vec
);
  logic [W-1:0] x, y;
  logic a_ge;

  always_comb begin
    a_ge   = (a_sig >= b_sig);
    x      = a_ge ? a_sig : b_sig;
    y      = a_ge ? b_sig : a_sig;
    diff_c = x - y;
    t_vec  = x ^ y;          // digit nonzero
    n_vec  = ~x & y;         // digit is -1
    // indicator: nonzero digit whose lower neighbour is not -1
    f_vec  = t_vec & ~{n_vec[W-2:0], 1'b0};
  end
endmodule

// File: rtl/lza_lzd.sv
module lza_lzd #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic [W-1:0]  f_vec,
  output logic [CW-1:0] pred_cnt,
  output logic          any_one
);
  localparam int NN = 2 * W - 1;

  logic          cv [NN];
  logic [CW-1:0] cc [NN];

  for (genvar k = 0; k < W; k++) begin : g_leaf
    assign cv[W-1+k] = f_vec[W-1-k];
    assign cc[W-1+k] = '0;
  end

  for (genvar i = 0; i < W - 1; i++) begin : g_node
    localparam int LV   = $clog2(i + 2) - 1;
    localparam int HALF = W >> (LV + 1);
    assign cv[i] = cv[2*i+1] | cv[2*i+2];
    assign cc[i] = cv[2*i+1] ? cc[2*i+1] : CW'(HALF) + cc[2*i+2];
  end

  assign any_one  = cv[0];
  assign pred_cnt = cv[0] ? cc[0] : CW'(W);
endmodule

// File: rtl/lza_err_tree.sv
module lza_err_tree
  import lza_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] f_vec,
  input  logic [W-1:0] t_vec,
  input  logic [W-1:0] n_vec,
  output logic         corr
);
  localparam int NN = 2 * W - 1;

  enode_t nd [NN];

  for (genvar k = 0; k < W; k++) begin : g_leaf
    assign nd[W-1+k] = err_leaf(f_vec[W-1-k], t_vec[W-1-k], n_vec[W-1-k]);
  end

  // first level joins bit pairs; upper levels keep only the pattern at the
  // most significant indicator position
  for (genvar i = 0; i < W - 1; i++) begin : g_node
    assign nd[i] = err_merge(nd[2*i+1], nd[2*i+2]);
  end

  assign corr = nd[0].v & nd[0].e;
endmodule

// File: rtl/lza_parallel_top.sv
module lza_parallel_top #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  a_sig,
  input  logic [W-1:0]  b_sig,
  output logic          out_valid,
  output logic [W-1:0]  diff,
  output logic [CW-1:0] lz_count,
  output logic          zero
);
  logic [W-1:0]  diff_c, t_vec, n_vec, f_vec;
  logic [CW-1:0] pred_cnt;
  logic          any_one;
  logic          corr;
  logic          pred_zero;
  logic [CW-1:0] cnt_c;

  lza_prep #(.W(W)) u_prep (
    .a_sig(a_sig), .b_sig(b_sig), .diff_c(diff_c),
    .t_vec(t_vec), .n_vec(n_vec), .f_vec(f_vec)
  );

  lza_lzd #(.W(W), .CW(CW)) u_lzd (
    .f_vec(f_vec), .pred_cnt(pred_cnt), .any_one(any_one)
  );

  lza_err_tree #(.W(W)) u_err (
    .f_vec(f_vec), .t_vec(t_vec), .n_vec(n_vec), .corr(corr)
  );

  assign pred_zero = ~any_one;
  assign cnt_c     = pred_cnt + CW'(corr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      diff      <= '0;
      lz_count  <= '0;
      zero      <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        diff     <= diff_c;
        lz_count <= cnt_c;
        zero     <= pred_zero;
      end
    end
  end
endmodule

// File: rtl/lza_chk.sv
module lza_chk #(
  parameter int W  = 32,
  parameter int CW = $clog2(W) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  a_sig,
  input logic [W-1:0]  b_sig,
  input logic          out_valid,
  input logic [W-1:0]  diff,
  input logic [CW-1:0] lz_count,
  input logic          zero,
  input logic [CW-1:0] pred_cnt,
  input logic          corr,
  input logic          pred_zero
);
  logic [W-1:0] norm;
  assign norm = diff << lz_count;

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R4
  AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(diff) && $stable(lz_count) && $stable(zero))); // R5
  AST_DIFF_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (diff == (($past(a_sig) >= $past(b_sig)) ? $past(a_sig) - $past(b_sig)
                                                          : $past(b_sig) - $past(a_sig)))); // R1
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (zero == (lz_count == CW'(W)))); // R3
  AST_NORMALIZED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !zero) |-> norm[W-1]); // R2
  AST_NO_CORR_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pred_zero |-> (!corr && pred_cnt == CW'(W))); // R7
endmodule

bind lza_parallel_top lza_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_sig(a_sig), .b_sig(b_sig),
  .out_valid(out_valid), .diff(diff), .lz_count(lz_count), .zero(zero),
  .pred_cnt(pred_cnt), .corr(corr), .pred_zero(pred_zero)
);

// File: tb/test_lza_parallel_top.sv
`timescale 1ns/1ps
module test_lza_parallel_top;
  localparam int W  = 32;
  localparam int CW = $clog2(W) + 1;
  localparam int NV = 8;

  localparam logic [W-1:0] VA [NV] = '{32'h0000_000C, 32'h4000_0000, 32'hA000_0000, 32'h0000_0064,
                                      32'h0001_0000, 32'h7FFF_FFFF, 32'h0000_0F00, 32'h5555_5555};
  localparam logic [W-1:0] VB [NV] = '{32'h0000_0003, 32'h1000_0000, 32'h5FFF_FFFF, 32'h0000_0025,
                                      32'h0000_FFFF, 32'h0000_0001, 32'h0000_00F0, 32'h2AAA_AAAA};
  localparam int           VL [NV] = '{28, 2, 1, 26, 31, 1, 20, 2};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [W-1:0]  a_sig = '0;
  logic [W-1:0]  b_sig = '0;
  logic          out_valid;
  logic [W-1:0]  diff;
  logic [CW-1:0] lz_count;
  logic          zero;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  lza_parallel_top #(.W(W), .CW(CW)) i_lza_parallel_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_sig(a_sig), .b_sig(b_sig),
    .out_valid(out_valid), .diff(diff), .lz_count(lz_count), .zero(zero)
  );

  function automatic int ref_lzc(logic [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) return W - 1 - i;
    return W;
  endfunction

  function automatic logic [W-1:0] ref_mag(logic [W-1:0] a, logic [W-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at a falling edge, result sampled at the next falling edge
  task automatic run(string req, logic [W-1:0] a, logic [W-1:0] b, int exp_lz);
    @(negedge clk);
    in_valid = 1'b1; a_sig = a; b_sig = b;
    @(negedge clk);
    chk("R4", "out_valid", out_valid, 1);
    chk("R1", "diff", diff, ref_mag(a, b));
    chk(req, "lz_count", lz_count, exp_lz);
    chk("R3", "zero", zero, (a == b) ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] s, ra, rb, hd, hl;
    logic hz;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6", "out_valid", out_valid, 0);
    chk("R6", "diff", diff, 0);
    chk("R6", "lz_count", lz_count, 0);
    chk("R6", "zero", zero, 0);
    rst_n = 1'b1;

    // table of vectors, general patterns, R2
    for (int i = 0; i < NV; i++) begin
      run("R2", VA[i], VB[i], VL[i]);
      chk("R2", "table vs model", VL[i], ref_lzc(ref_mag(VA[i], VB[i])));
    end

    // R7 correction patterns
    run("R7", 32'd8, 32'd3, 29);
    run("R7", 32'd8, 32'd1, 29);
    // R8 borrow runs
    run("R8", 32'h8000_0000, 32'h7FFF_FFFF, 31);
    run("R8", 32'h8000_0000, 32'h7FFF_FFFE, 30);
    // R9 swapped operands
    run("R9", 32'd3, 32'd8, 29);
    run("R9", 32'h7FFF_FFFF, 32'h8000_0000, 31);
    // R10 extremes, R3 zero
    run("R10", 32'hFFFF_FFFF, 32'h0, 0);
    run("R10", 32'h0, 32'h0, W);
    run("R3", 32'h1234_5678, 32'h1234_5678, W);

    // R5 hold while idle
    run("R2", 32'd100, 32'd37, 26);
    hd = diff; hl = W'(lz_count); hz = zero;
    @(negedge clk);
    in_valid = 1'b0; a_sig = 32'h0; b_sig = 32'hFFFF_0000;
    @(negedge clk);
    chk("R4", "out_valid idle", out_valid, 0);
    chk("R5", "diff held", diff, hd);
    chk("R5", "lz_count held", lz_count, hl);
    chk("R5", "zero held", zero, hz);

    // R2 pseudo-random near-equal and general pairs
    s = 32'h1ACE_B00C;
    for (int i = 0; i < 400; i++) begin
      s ^= s << 13; s ^= s >> 17; s ^= s << 5; ra = s;
      s ^= s << 13; s ^= s >> 17; s ^= s << 5;
      case (i % 4)
        0: rb = ra - (s & 32'hFF);
        1: rb = s;
        2: rb = ra ^ (32'h1 << s[4:0]);
        default: rb = (ra >> s[2:0]) | (s & 32'hF);
      endcase
      run("R2", ra, rb, ref_lzc(ref_mag(ra, rb)));
    end

    @(negedge clk);
    in_valid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule